// File: doc/BRIEF.md
# Smart-card ETU rate generator

The block converts the first interface byte of a smart-card answer-to-reset into an elementary time unit (ETU) timing reference. The byte holds two 4-bit codes. The upper code picks the clock-rate factor Fi and the highest card clock frequency. The lower code picks the baud-rate divisor Di. A flag input says that the card did not send the byte, and the block then uses the default code 0x11. The decoded Fi, Di and frequency limit are driven out, together with an error flag that marks reserved codes.

From the latched setting, the block gives a one-cycle tick on the card-clock domain. The ETU length Fi/Di is often not a whole number of cycles, so the block keeps a fractional accumulator: it adds Di on each enabled cycle and takes off Fi whenever the sum reaches Fi. Over any run of Di ticks this comes to exactly Fi clock cycles. A character-framing engine downstream uses the tick as its bit strobe.

A new setting takes effect only on a load strobe, and the load restarts the ETU phase. An enable input pauses the count without losing phase.

Top module: `etu_rate_gen`

## Requirements
- R1: After synchronous reset, fi_o = 372, di_o = 1, fmax_o = 50, err_o = 0 and tick_o = 0. The accumulator is cleared, so the first tick comes on the 372nd enabled cycle after reset is released.
- R2: Di decode from code bits [3:0]: 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→64, 8→12, 9→20. The values 0 and 10 to 15 are reserved.
- R3: Fi and fmax decode from code bits [7:4], with fmax in units of 100 kHz: 0→372/40, 1→372/50, 2→558/60, 3→744/80, 4→1116/120, 5→1488/160, 6→1860/200, 9→512/50, 10→768/75, 11→1024/100, 12→1536/150, 13→2048/200. The values 7, 8, 14 and 15 are reserved.
- R4: When absent_i is high during a load, the block ignores ta1_i and uses code 0x11, so Fi = 372, Di = 1, fmax = 50 and err_o = 0.
- R5: A load with a reserved value in either 4-bit field sets err_o = 1 and drives the outputs with the 0x11 decode (372, 1, 50). No tick is given until a later valid load or a reset.
- R6: The decoded outputs change only on a cycle with load_i high. A change on ta1_i or absent_i without a load has no effect.
- R7: A load clears the accumulator. With enable held high, the Di-th tick after the load comes exactly on the Fi-th clock cycle after the load, for every valid code.
- R8: While en_i is low, the accumulator holds its value and no tick is given. When en_i returns high, counting picks up from the held phase.
- R9: Codes that give the same Fi/Di ratio give the same tick timing. For example, 0xA8 and 0xD6 both tick every 64 cycles.
- R10: tick_o is high for one cycle at a time. It is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Latch a new setting and restart the ETU phase |
| absent_i | input | 1 | The interface byte was not sent; use 0x11 |
| ta1_i | input | 8 | Interface byte: [7:4] Fi/fmax code, [3:0] Di code |
| en_i | input | 1 | Count enable |
| tick_o | output | 1 | One-cycle pulse per ETU |
| fi_o | output | 12 | Decoded clock-rate factor Fi |
| di_o | output | 7 | Decoded baud-rate divisor Di |
| fmax_o | output | 8 | Highest card clock, in units of 100 kHz |
| err_o | output | 1 | Reserved code seen at the last load |

## Verification
All 256 byte values are loaded. Each valid one is timed from the load to its Di-th tick, so an error in the ratio shows up as a wrong cycle count, and an error in the decode shows up as a wrong field. The reserved values separate the two fields: a reserved upper code alone, and a reserved lower code alone, must each raise the error flag and stop the ticks. Directed runs compare two codes with the same ratio, pause the enable partway through an ETU, change the byte without a load, and give the absent flag together with a reserved byte, so that a correct phase cannot be confused with a restarted or frozen one.

// File: rtl/etu_pkg.sv
package etu_pkg;

    localparam int FI_W   = 12;
    localparam int DI_W   = 7;
    localparam int FMAX_W = 8;
    localparam int CODE_W = 8;

    typedef struct packed {
        logic [FI_W-1:0]   fi;
        logic [DI_W-1:0]   di;
        logic [FMAX_W-1:0] fmax;
        logic              err;
    } cfg_t;

    localparam logic [CODE_W-1:0] CODE_DEFAULT = 8'h11;

    localparam cfg_t CFG_DEFAULT = '{
        fi:   FI_W'(372),
        di:   DI_W'(1),
        fmax: FMAX_W'(50),
        err:  1'b0
    };

endpackage

// File: rtl/etu_ta1_decode.sv
module etu_ta1_decode
    import etu_pkg::*;
#(
    parameter int FI_W_P   = FI_W,
    parameter int DI_W_P   = DI_W,
    parameter int FMAX_W_P = FMAX_W
) (
    input  logic [7:0]          code_i,
    output logic [FI_W_P-1:0]   fi_o,
    output logic [DI_W_P-1:0]   di_o,
    output logic [FMAX_W_P-1:0] fmax_o,
    output logic                rsvd_o
);

    logic [3:0] rate_sel;
    logic [3:0] div_sel;
    logic       rate_bad;
    logic       div_bad;

    assign rate_sel = code_i[7:4];
    assign div_sel  = code_i[3:0];

    always_comb begin
        rate_bad = 1'b0;
        fi_o     = FI_W_P'(372);
        fmax_o   = FMAX_W_P'(50);
        case (rate_sel)
            4'h0: begin fi_o = FI_W_P'(372);  fmax_o = FMAX_W_P'(40);  end
            4'h1: begin fi_o = FI_W_P'(372);  fmax_o = FMAX_W_P'(50);  end
            4'h2: begin fi_o = FI_W_P'(558);  fmax_o = FMAX_W_P'(60);  end
            4'h3: begin fi_o = FI_W_P'(744);  fmax_o = FMAX_W_P'(80);  end
            4'h4: begin fi_o = FI_W_P'(1116); fmax_o = FMAX_W_P'(120); end
            4'h5: begin fi_o = FI_W_P'(1488); fmax_o = FMAX_W_P'(160); end
            4'h6: begin fi_o = FI_W_P'(1860); fmax_o = FMAX_W_P'(200); end
            4'h9: begin fi_o = FI_W_P'(512);  fmax_o = FMAX_W_P'(50);  end
            4'hA: begin fi_o = FI_W_P'(768);  fmax_o = FMAX_W_P'(75);  end
            4'hB: begin fi_o = FI_W_P'(1024); fmax_o = FMAX_W_P'(100); end
            4'hC: begin fi_o = FI_W_P'(1536); fmax_o = FMAX_W_P'(150); end
            4'hD: begin fi_o = FI_W_P'(2048); fmax_o = FMAX_W_P'(200); end
            default: rate_bad = 1'b1;
        endcase
    end

    always_comb begin
        div_bad = 1'b0;
        di_o    = DI_W_P'(1);
        case (div_sel)
            4'h1: di_o = DI_W_P'(1);
            4'h2: di_o = DI_W_P'(2);
            4'h3: di_o = DI_W_P'(4);
            4'h4: di_o = DI_W_P'(8);
            4'h5: di_o = DI_W_P'(16);
            4'h6: di_o = DI_W_P'(32);
            4'h7: di_o = DI_W_P'(64);
            4'h8: di_o = DI_W_P'(12);
            4'h9: di_o = DI_W_P'(20);
            default: div_bad = 1'b1;
        endcase
    end

    assign rsvd_o = rate_bad | div_bad;

    // Every legal Fi exceeds twice every legal Di, which keeps ticks apart
    always_comb begin
        if (!rsvd_o) begin
            AST_RATIO_ABOVE_TWO: assert ({1'b0, fi_o} > ({(FI_W_P+1-DI_W_P)'(0), di_o} << 1)); // R10
        end
    end

endmodule

// File: rtl/etu_frac_div.sv
module etu_frac_div
    import etu_pkg::*;
#(
    parameter int FI_W_P = FI_W,
    parameter int DI_W_P = DI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [FI_W_P-1:0] fi_i,
    input  logic [DI_W_P-1:0] di_i,
    output logic              tick_o
);

    localparam int ACC_W = FI_W_P + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        sum       = st_q.acc + ACC_W'(di_i);
        if (clr_i) begin
            st_d.acc = '0;
        end else if (run_i) begin
            if (sum >= ACC_W'(fi_i)) begin
                st_d.acc  = sum - ACC_W'(fi_i);
                st_d.tick = 1'b1;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_ACC_BELOW_FI: assert property (@(posedge clk) disable iff (rst)
        st_q.acc < ACC_W'(fi_i)); // R7

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clr_i) |=> ($stable(st_q.acc) && !tick_o)); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (st_q.acc == '0 && !tick_o)); // R7

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R10

endmodule

// File: rtl/etu_rate_gen.sv
module etu_rate_gen
    import etu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              absent_i,
    input  logic [CODE_W-1:0] ta1_i,
    input  logic              en_i,
    output logic              tick_o,
    output logic [FI_W-1:0]   fi_o,
    output logic [DI_W-1:0]   di_o,
    output logic [FMAX_W-1:0] fmax_o,
    output logic              err_o
);

    cfg_t cfg_d, cfg_q;
    cfg_t dec;
    logic [CODE_W-1:0] code_sel;
    logic              run;

    assign code_sel = absent_i ? CODE_DEFAULT : ta1_i;

    etu_ta1_decode #(
        .FI_W_P   (FI_W),
        .DI_W_P   (DI_W),
        .FMAX_W_P (FMAX_W)
    ) i_decode (
        .code_i (code_sel),
        .fi_o   (dec.fi),
        .di_o   (dec.di),
        .fmax_o (dec.fmax),
        .rsvd_o (dec.err)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            if (dec.err) begin
                cfg_d     = CFG_DEFAULT;
                cfg_d.err = 1'b1;
            end else begin
                cfg_d = dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_DEFAULT;
        else     cfg_q <= cfg_d;
    end

    assign run = en_i & ~cfg_q.err;

    etu_frac_div #(
        .FI_W_P (FI_W),
        .DI_W_P (DI_W)
    ) i_div (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load_i),
        .run_i  (run),
        .fi_i   (cfg_q.fi),
        .di_i   (cfg_q.di),
        .tick_o (tick_o)
    );

    assign fi_o   = cfg_q.fi;
    assign di_o   = cfg_q.di;
    assign fmax_o = cfg_q.fmax;
    assign err_o  = cfg_q.err;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cfg_q)); // R6

    AST_ERR_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !tick_o); // R5

    AST_ERR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (fi_o == FI_W'(372) && di_o == DI_W'(1) && fmax_o == FMAX_W'(50))); // R5

    AST_ABSENT_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (load_i && absent_i) |=> (!err_o && fi_o == FI_W'(372) && di_o == DI_W'(1))); // R4

    AST_DI_NONZERO: assert property (@(posedge clk) disable iff (rst)
        di_o != '0); // R2

endmodule

// File: tb/test_etu_rate_gen.sv
module test_etu_rate_gen;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 195000;

    typedef struct packed {
        logic [7:0]  code;
        logic        absent;
        logic [11:0] fi;
        logic [6:0]  di;
        logic [7:0]  fmax;
        logic        err;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{code: 8'h96, absent: 1'b0, fi: 12'd512,  di: 7'd32, fmax: 8'd50,  err: 1'b0},
        '{code: 8'hA8, absent: 1'b0, fi: 12'd768,  di: 7'd12, fmax: 8'd75,  err: 1'b0},
        '{code: 8'hD6, absent: 1'b0, fi: 12'd2048, di: 7'd32, fmax: 8'd200, err: 1'b0},
        '{code: 8'h00, absent: 1'b1, fi: 12'd372,  di: 7'd1,  fmax: 8'd50,  err: 1'b0},
        '{code: 8'h3F, absent: 1'b0, fi: 12'd372,  di: 7'd1,  fmax: 8'd50,  err: 1'b1},
        '{code: 8'h71, absent: 1'b0, fi: 12'd372,  di: 7'd1,  fmax: 8'd50,  err: 1'b1},
        '{code: 8'h09, absent: 1'b0, fi: 12'd372,  di: 7'd20, fmax: 8'd40,  err: 1'b0},
        '{code: 8'h47, absent: 1'b0, fi: 12'd1116, di: 7'd64, fmax: 8'd120, err: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic        absent_i = 1'b0;
    logic [7:0]  ta1_i = 8'h00;
    logic        en_i = 1'b1;
    logic        tick_o;
    logic [11:0] fi_o;
    logic [6:0]  di_o;
    logic [7:0]  fmax_o;
    logic        err_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    etu_rate_gen i_etu_rate_gen (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .absent_i (absent_i),
        .ta1_i    (ta1_i),
        .en_i     (en_i),
        .tick_o   (tick_o),
        .fi_o     (fi_o),
        .di_o     (di_o),
        .fmax_o   (fmax_o),
        .err_o    (err_o)
    );

    function automatic int ref_fi(input logic [3:0] h);
        case (h)
            4'h0, 4'h1: return 372;
            4'h2: return 558;
            4'h3: return 744;
            4'h4: return 1116;
            4'h5: return 1488;
            4'h6: return 1860;
            4'h9: return 512;
            4'hA: return 768;
            4'hB: return 1024;
            4'hC: return 1536;
            4'hD: return 2048;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_fmax(input logic [3:0] h);
        case (h)
            4'h0: return 40;
            4'h1, 4'h9: return 50;
            4'h2: return 60;
            4'h3: return 80;
            4'h4: return 120;
            4'h5: return 160;
            4'h6, 4'hD: return 200;
            4'hA: return 75;
            4'hB: return 100;
            4'hC: return 150;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_di(input logic [3:0] l);
        case (l)
            4'h1: return 1;
            4'h2: return 2;
            4'h3: return 4;
            4'h4: return 8;
            4'h5: return 16;
            4'h6: return 32;
            4'h7: return 64;
            4'h8: return 12;
            4'h9: return 20;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic do_load(input logic [7:0] code, input logic absent);
        @(negedge clk);
        ta1_i    = code;
        absent_i = absent;
        load_i   = 1'b1;
        @(negedge clk);
        load_i   = 1'b0;
        absent_i = 1'b0;
    endtask

    // Cycles from the last load/reset edge until the n-th tick
    task automatic count_to_ticks(input int n, output int cyc);
        int seen;
        seen = 0;
        cyc  = 0;
        while (seen < n && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (tick_o) seen++;
        end
    endtask

    task automatic count_ticks_in(input int len, output int seen);
        seen = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (tick_o) seen++;
        end
    endtask

    task automatic check_cfg(input string req, input int fi, input int di, input int fm, input int er);
        chk(int'(fi_o) == fi,   req, "fi",   int'(fi_o),   fi);
        chk(int'(di_o) == di,   req, "di",   int'(di_o),   di);
        chk(int'(fmax_o) == fm, req, "fmax", int'(fmax_o), fm);
        chk(int'(err_o) == er,  req, "err",  int'(err_o),  er);
    endtask

    initial begin
        wait (cycles >= WATCHDOG);
        chk(1'b0, "WATCHDOG", "cycles", cycles, WATCHDOG);
        finish_run();
    end

    initial begin
        int cyc;
        int seen;
        int first;

        // R1: reset state and first tick after release
        repeat (3) @(negedge clk);
        check_cfg("R1", 372, 1, 50, 0);
        chk(tick_o == 1'b0, "R1", "tick in reset", int'(tick_o), 0);
        rst = 1'b0;
        count_to_ticks(1, cyc);
        chk(cyc == 372, "R1", "first tick after reset", cyc, 372);

        // Table of vectors
        for (int v = 0; v < NVEC; v++) begin
            do_load(VECS[v].code, VECS[v].absent);
            check_cfg(VECS[v].absent ? "R4" : (VECS[v].err ? "R5" : "R3"),
                      int'(VECS[v].fi), int'(VECS[v].di), int'(VECS[v].fmax), int'(VECS[v].err));
            if (VECS[v].err) begin
                count_ticks_in(3000, seen);
                chk(seen == 0, "R5", "ticks while in error", seen, 0);
            end else begin
                count_to_ticks(int'(VECS[v].di), cyc);
                chk(cyc == int'(VECS[v].fi), "R7", "cycles to Di ticks", cyc, int'(VECS[v].fi));
            end
        end

        // Sweep of every byte value: decode, error flag, cycle count over Di ticks
        for (int c = 0; c < 256; c++) begin
            int efi;
            int edi;
            int efm;
            efi = ref_fi(c[7:4]);
            edi = ref_di(c[3:0]);
            efm = ref_fmax(c[7:4]);
            do_load(c[7:0], 1'b0);
            if (efi == 0 || edi == 0) begin
                check_cfg("R5", 372, 1, 50, 1);
                count_ticks_in(20, seen);
                chk(seen == 0, "R5", "ticks after reserved load", seen, 0);
            end else begin
                chk(int'(di_o) == edi,   "R2", "di", int'(di_o), edi);
                chk(int'(fi_o) == efi,   "R3", "fi", int'(fi_o), efi);
                chk(int'(fmax_o) == efm, "R3", "fmax", int'(fmax_o), efm);
                chk(err_o == 1'b0,       "R3", "err", int'(err_o), 0);
                count_to_ticks(edi, cyc);
                chk(cyc == efi, "R7", "cycles to Di ticks", cyc, efi);
            end
        end

        // R9: equal ratios tick alike
        do_load(8'hA8, 1'b0);
        count_to_ticks(1, first);
        count_to_ticks(1, cyc);
        chk(first == 64 && cyc == 64, "R9", "0xA8 tick spacing", cyc, 64);
        do_load(8'hD6, 1'b0);
        count_to_ticks(1, first);
        count_to_ticks(1, cyc);
        chk(first == 64 && cyc == 64, "R9", "0xD6 tick spacing", cyc, 64);

        // R8: pause partway through an ETU
        do_load(8'h11, 1'b0);
        count_ticks_in(100, seen);
        en_i = 1'b0;
        count_ticks_in(500, seen);
        chk(seen == 0, "R8", "ticks while disabled", seen, 0);
        en_i = 1'b1;
        count_to_ticks(1, cyc);
        chk(cyc == 272, "R8", "cycles after resume", cyc, 272);

        // R6: byte change without a load is ignored
        @(negedge clk);
        ta1_i    = 8'h96;
        absent_i = 1'b1;
        repeat (5) @(negedge clk);
        check_cfg("R6", 372, 1, 50, 0);
        absent_i = 1'b0;

        // R5: leave error through a valid load
        do_load(8'h1A, 1'b0);
        check_cfg("R5", 372, 1, 50, 1);
        do_load(8'h13, 1'b0);
        check_cfg("R5", 372, 4, 50, 0);
        count_to_ticks(4, cyc);
        chk(cyc == 372, "R5", "ticks resume after valid load", cyc, 372);

        // R1: reset mid-run restores default and restarts phase
        do_load(8'h96, 1'b0);
        count_ticks_in(7, seen);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_cfg("R1", 372, 1, 50, 0);
        count_to_ticks(1, cyc);
        chk(cyc == 372, "R1", "first tick after mid-run reset", cyc, 372);

        finish_run();
    end

endmodule